// File: doc/BRIEF.md
# End-Stopped Two-Digit Up/Down Occupancy Counter

This block tracks how many items or people are inside an enclosure, using two BCD digits (00 to 99). Each event strobe comes with a direction level, and the count moves by one step per strobe. The count does not wrap at either end. When it reaches 99 while counting up, or 00 while counting down, further strobes in that direction have no effect. The count leaves an end only when a strobe arrives in the opposite direction.

A compile-time parameter selects between two modes. In occupied mode the count is the number present. FULL is raised when the count equals a programmable BCD capacity, so limits below 99 are possible. In spaces-left mode a load command copies the capacity into the count. Each entry then lowers the count and each exit raises it, and FULL means that no space is left.

A synchronous load command takes priority over all strobes. A manual select lets an operator step the count upward to correct it. While manual select is high the event strobe is ignored.

Top module: `occ_counter`

## Requirements
- R1: A synchronous active-low reset `rst_n` clears both digits to 00 on the next rising clock edge.
- R2: In occupied mode, with manual select low, an accepted `evt` with `evt_up`=1 raises the count by one. The count is held as {`digit_hi`,`digit_lo`} in BCD, and a low digit of 9 rolls to 0 while the high digit increments (09 to 10).
- R3: In occupied mode, an accepted `evt` with `evt_up`=0 lowers the count by one. A low digit of 0 becomes 9 while the high digit decrements (10 to 09).
- R4: `tc` is combinational. It is 1 exactly when the current counting direction is up and the count is 99, or when the direction is down and the count is 00.
- R5: A strobe arriving while `tc` is 1 leaves the count unchanged. A strobe in the opposite direction is still accepted, so the count moves off the end.
- R6: `load` high on a rising edge replaces the count with the load target, whatever strobes arrive in that cycle. In occupied mode the load target is `load_val`.
- R7: In occupied mode, `full` is 1 exactly when the count equals the BCD value on `cap`.
- R8: While `man_sel` is 1, `evt` is ignored, even in the same cycle as `man_inc`. Each `man_inc` raises the count by one, the counting direction is treated as up for `tc`, and the count stops at 99.
- R9: With `SPACES_LEFT`=1, `load` copies `cap` into the count. `evt` with `evt_up`=1 (an entry) lowers the count, `evt` with `evt_up`=0 (an exit) raises it, and `full` is 1 exactly when the count is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | 1 | One-cycle event strobe |
| evt_up | input | 1 | Event direction: 1 = entry/up, 0 = exit/down |
| load | input | 1 | Synchronous load command, highest priority |
| load_val | input | 8 | BCD load value used in occupied mode |
| man_sel | input | 1 | Manual correction mode select |
| man_inc | input | 1 | Manual increment strobe |
| cap | input | 8 | BCD capacity |
| digit_lo | output | 4 | Units BCD digit |
| digit_hi | output | 4 | Tens BCD digit |
| tc | output | 1 | Terminal count in the current direction |
| full | output | 1 | Capacity reached / no space left |

## Verification
The bench pushes the count across the digit boundary in both directions. A design with a wrong carry or borrow would produce a non-BCD digit or skip a value at 09/10. It parks the count at 99 and at 00 and sends more strobes the same way; a design without the end stop would wrap to 00 or 99. It then reverses direction to confirm the count is not locked at the end. Further cases cover a load that coincides with an event, a manual strobe paired with a contrary event, a capacity below 99 where FULL must clear again one step past it, and the spaces-left variant, where an inverted direction mapping or a FULL decoded against the capacity would show up at once.

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter bit SPACES_LEFT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       evt_up,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       man_sel,
  input  logic       man_inc,
  input  logic [7:0] cap,
  output logic [3:0] digit_lo,
  output logic [3:0] digit_hi,
  output logic       tc,
  output logic       full
);

  logic [3:0] lo_q, hi_q;

  wire       cnt_up   = man_sel ? 1'b1 : (SPACES_LEFT ? ~evt_up : evt_up);
  wire       stb      = man_sel ? man_inc : evt;
  wire       lo_end   = cnt_up ? (lo_q == 4'd9) : (lo_q == 4'd0);
  wire       hi_end   = cnt_up ? (hi_q == 4'd9) : (hi_q == 4'd0);
  wire       at_end   = lo_end & hi_end;
  wire       adv      = stb & ~at_end;
  wire [7:0] load_tgt = SPACES_LEFT ? cap : load_val;
  wire [7:0] cnt      = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= 4'd0;
      hi_q <= 4'd0;
    end else if (load) begin
      {hi_q, lo_q} <= load_tgt;
    end else if (adv) begin
      if (lo_end) begin
        lo_q <= cnt_up ? 4'd0 : 4'd9;
        hi_q <= cnt_up ? hi_q + 4'd1 : hi_q - 4'd1;
      end else begin
        lo_q <= cnt_up ? lo_q + 4'd1 : lo_q - 4'd1;
      end
    end
  end

  assign digit_lo = lo_q;
  assign digit_hi = hi_q;
  assign tc       = at_end;
  assign full     = SPACES_LEFT ? (cnt == 8'h00) : (cnt == cap);

  wire [6:0] bin = {3'b0, hi_q} * 7'd10 + {3'b0, lo_q};

  // R2
  bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q <= 4'd9) && (hi_q <= 4'd9));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && stb && cnt_up && bin != 7'd99) |=> (bin == $past(bin) + 7'd1));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && stb && !cnt_up && bin != 7'd0) |=> (bin == $past(bin) - 7'd1));

  // R5
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tc) |=> $stable(bin));

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ({digit_hi, digit_lo} == $past(load_tgt)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !stb) |=> $stable(bin));

endmodule

// File: tb/sim_occ_counter.sv
module sim_occ_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0, evt_up = 1'b1, load = 1'b0;
  logic       man_sel = 1'b0, man_inc = 1'b0;
  logic [7:0] load_val = 8'h00, cap = 8'h05;
  logic [3:0] lo0, hi0, lo1, hi1;
  logic       tc0, full0, tc1, full1;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  occ_counter #(.SPACES_LEFT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_up(evt_up), .load(load),
    .load_val(load_val), .man_sel(man_sel), .man_inc(man_inc), .cap(cap),
    .digit_lo(lo0), .digit_hi(hi0), .tc(tc0), .full(full0));

  occ_counter #(.SPACES_LEFT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_up(evt_up), .load(load),
    .load_val(load_val), .man_sel(man_sel), .man_inc(man_inc), .cap(cap),
    .digit_lo(lo1), .digit_hi(hi1), .tc(tc1), .full(full1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic up, input logic ld, input logic mi);
    @(negedge clk);
    evt = e; evt_up = up; load = ld; man_inc = mi;
    @(negedge clk);
    evt = 1'b0; load = 1'b0; man_inc = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; evt_up = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset count", {hi0, lo0}, 8'h00);
    chk("R4 tc at 00 going down", {7'd0, tc0}, 8'h01);
    chk("R7 full off below cap", {7'd0, full0}, 8'h00);
  endtask

  task automatic t_up_down;
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 count up across 09/10", {hi0, lo0}, 8'h12);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 count down across 10/09", {hi0, lo0}, 8'h09);
  endtask

  task automatic t_ends;
    load_val = 8'h97;
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 load beats same-cycle event", {hi0, lo0}, 8'h97);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 reach 99", {hi0, lo0}, 8'h99);
    chk("R4 tc at 99 going up", {7'd0, tc0}, 8'h01);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 held at 99", {hi0, lo0}, 8'h99);
    evt_up = 1'b0; #1;
    chk("R4 no tc at 99 going down", {7'd0, tc0}, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 leave 99 downward", {hi0, lo0}, 8'h98);
    load_val = 8'h00;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 held at 00", {hi0, lo0}, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 leave 00 upward", {hi0, lo0}, 8'h01);
  endtask

  task automatic t_full;
    cap = 8'h03; load_val = 8'h02;
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 full off at 02", {7'd0, full0}, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 full on at cap 03", {7'd0, full0}, 8'h01);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 full off past cap", {7'd0, full0}, 8'h00);
  endtask

  task automatic t_manual;
    load_val = 8'h40;
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    man_sel = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 manual wins over event", {hi0, lo0}, 8'h41);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 event ignored in manual", {hi0, lo0}, 8'h41);
    load_val = 8'h98;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 manual stops at 99", {hi0, lo0}, 8'h99);
    chk("R8 manual tc treated as up", {7'd0, tc0}, 8'h01);
    man_sel = 1'b0;
  endtask

  task automatic t_spaces;
    cap = 8'h25;
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 load copies capacity", {hi1, lo1}, 8'h25);
    chk("R9 full off with spaces", {7'd0, full1}, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 entry lowers count", {hi1, lo1}, 8'h24);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 exit raises count", {hi1, lo1}, 8'h25);
    cap = 8'h01;
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 full at zero spaces", {7'd0, full1}, 8'h01);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 held at 00 on entry", {hi1, lo1}, 8'h00);
    chk("R9 tc at 00 on entry", {7'd0, tc1}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_up_down;
    t_ends;
    t_full;
    t_manual;
    t_spaces;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule